// File: doc/BRIEF.md
# UART Receiver with Error Capture

This block turns an asynchronous serial line into bytes. A baud-rate strobe arrives from outside at sixteen times the bit rate. The line passes through a two-stage synchronizer, and a deframer state machine samples each bit at its middle. Each character has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A completed character goes into a one-entry holding register and raises a data-valid flag. A pulse on a read strobe consumes the byte and drops that flag.

Four line conditions are kept as sticky flags in an error register: a byte lost to overrun, bad parity, a missing stop bit, and a break. A break is a line held low for longer than a whole frame. Software clears the flags one at a time by writing ones. A four-bit enable register switches the receiver on only when it holds one particular code. With any other value the receiver stays idle, and the error flags and the holding register keep their contents.

Top module: `uart_rx_errcap`

## Requirements
- R1: After a synchronous reset, err_flags, rx_valid, rx_data and en_rdata are all zero.
- R2: en_wdata is stored into the enable register when en_wr is high, and en_rdata reads it back. The receiver runs only while that register equals 4'd8. Every other value, including 4'd1, leaves the receiver idle.
- R3: Bits are sampled at the middle of each bit period, counted as 16 sub_tick pulses per bit, with data least significant bit first. When the stop bit is sampled, the byte is written to rx_data and rx_valid is set. This also happens when the frame has errors.
- R4: With parity_en high, a parity bit follows the data. For even parity (parity_odd=0) the data bits and the parity bit together hold an even number of ones; for odd parity they hold an odd number. A mismatch sets err_flags bit 1. With parity_en low, no parity bit is expected and bit 1 is never set.
- R5: A stop bit sampled low sets err_flags bit 2. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: A start bit confirmed at its middle while rx_valid is still set sets err_flags bit 0. The new byte then replaces the unread one.
- R7: When the line stays low for more than 160 sub_ticks (parity off) or more than 176 sub_ticks (parity on), err_flags bit 3 is set, once per low period.
- R8: A start bit that is high again at its middle is dropped. No byte is stored and no flag is set.
- R9: A rd_strobe pulse clears rx_valid. A byte that completes in the same cycle takes precedence and leaves rx_valid set.
- R10: Error flags are sticky. An err_wr cycle clears each flag whose err_wdata bit is 1 and leaves the others alone. A new error in the same cycle wins over the clear.
- R11: While the receiver is disabled it ignores the line. err_flags, rx_data and rx_valid keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd_in | input | 1 | Asynchronous serial data line, idle high |
| parity_en | input | 1 | Expect and check a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 4 | Enable register write value |
| en_rdata | output | 4 | Enable register contents |
| rd_strobe | input | 1 | Consume the held byte |
| rx_data | output | 8 | Holding register contents |
| rx_valid | output | 1 | Holding register holds an unread byte |
| err_wr | input | 1 | Write strobe for the error register |
| err_wdata | input | 4 | Write-one-to-clear mask |
| err_flags | output | 4 | Sticky flags: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break |

## Verification
The assertions check the register rules on every cycle. Flags only drop through a clear write. A clear removes exactly the masked bits. A detected error always lands in the flags. A finished byte always raises rx_valid, and a read without a competing byte drops it. While the enable code is wrong, no flag and no byte can appear. Only the bench's scenarios can show the deframing itself. These scenarios cover bit order, the parity sense, overrun replacement, glitch rejection, and the parity-dependent break threshold, which is checked with low periods that sit between the two frame lengths.

// File: rtl/uart_rx_errcap_pkg.sv
package uart_rx_errcap_pkg;

    localparam int           RX_OVS    = 16;
    localparam int           RX_DATA_W = 8;
    localparam int           RX_EN_W   = 4;
    localparam logic [3:0]   RX_EN_ON  = 4'd8;

    // Packed so that overrun lands at bit 0 and break at bit 3.
    typedef struct packed {
        logic brk;
        logic framing;
        logic parity;
        logic overrun;
    } rx_err_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    function automatic logic parity_wrong(input logic data_xor,
                                          input logic pbit,
                                          input logic odd);
        return (data_xor ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= {STAGES{RESET_VAL}};
        else
            chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_errcap_pkg::*;
#(
    parameter int DATA_W = RX_DATA_W,
    parameter int OVS    = RX_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sub_tick,
    input  logic              rx_bit,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              hold_full,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              par_bad,
    output logic              stop_bad,
    output logic              overrun_hit
);
    localparam int               CNT_W = $clog2(OVS);
    localparam int               IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID   = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_err_q;
    logic              at_mid, at_last;

    assign at_mid  = sub_tick && (cnt_q == MID);
    assign at_last = sub_tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            par_err_q <= 1'b0;
            if (rst) shift_q <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!rx_bit) state_q <= RX_START;
                end
                RX_START: begin
                    if (at_mid) begin
                        cnt_q     <= '0;
                        idx_q     <= '0;
                        par_err_q <= 1'b0;
                        state_q   <= rx_bit ? RX_IDLE : RX_DATA;
                    end else if (sub_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_last) begin
                        cnt_q   <= '0;
                        shift_q <= {rx_bit, shift_q[DATA_W-1:1]};
                        if (idx_q == TOP)
                            state_q <= parity_en ? RX_PARITY : RX_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end else if (sub_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (at_last) begin
                        cnt_q     <= '0;
                        par_err_q <= parity_wrong(^shift_q, rx_bit, parity_odd);
                        state_q   <= RX_STOP;
                    end else if (sub_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_last) begin
                        cnt_q   <= '0;
                        state_q <= rx_bit ? RX_IDLE : RX_WAIT_HIGH;
                    end else if (sub_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (rx_bit) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign frame_done  = enable && (state_q == RX_STOP) && at_last;
    assign frame_data  = shift_q;
    assign par_bad     = parity_en && par_err_q;
    assign stop_bad    = !rx_bit;
    assign overrun_hit = enable && (state_q == RX_START) && at_mid
                         && !rx_bit && hold_full;
endmodule

// File: rtl/uart_rx_break_det.sv
module uart_rx_break_det
    import uart_rx_errcap_pkg::*;
#(
    parameter int DATA_W = RX_DATA_W,
    parameter int OVS    = RX_OVS
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sub_tick,
    input  logic rx_bit,
    input  logic parity_en,
    output logic brk_hit
);
    localparam int LIM_NOPAR = OVS * (DATA_W + 2);
    localparam int LIM_PAR   = OVS * (DATA_W + 3);
    localparam int CW        = $clog2(LIM_PAR + 2);

    logic [CW-1:0] low_q;
    logic [CW-1:0] limit;

    assign limit = parity_en ? CW'(LIM_PAR) : CW'(LIM_NOPAR);

    always_ff @(posedge clk) begin
        if (rst || !enable || rx_bit)
            low_q <= '0;
        else if (sub_tick && (low_q <= limit))
            low_q <= low_q + 1'b1;
    end

    assign brk_hit = enable && !rx_bit && sub_tick && (low_q == limit);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_errcap_pkg::*;
#(
    parameter int DATA_W = RX_DATA_W,
    parameter int EN_W   = RX_EN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic              err_wr,
    input  logic [3:0]        err_wdata,
    input  rx_err_t           err_set,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              rd_strobe,
    output logic [EN_W-1:0]   en_code,
    output logic              rx_enabled,
    output logic [3:0]        err_q,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid
);
    logic [3:0] clr_mask;

    assign clr_mask = err_wr ? err_wdata : 4'b0000;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_code    <= '0;
            err_q      <= '0;
            hold_data  <= '0;
            hold_valid <= 1'b0;
        end else begin
            if (en_wr) en_code <= en_wdata;
            err_q <= (err_q & ~clr_mask) | err_set;
            if (frame_done) begin
                hold_data  <= frame_data;
                hold_valid <= 1'b1;
            end else if (rd_strobe) begin
                hold_valid <= 1'b0;
            end
        end
    end

    assign rx_enabled = (en_code == EN_W'(RX_EN_ON));
endmodule

// File: rtl/uart_rx_errcap.sv
module uart_rx_errcap
    import uart_rx_errcap_pkg::*;
#(
    parameter int DATA_W = RX_DATA_W,
    parameter int OVS    = RX_OVS,
    parameter int EN_W   = RX_EN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_tick,
    input  logic              rxd_in,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    output logic [EN_W-1:0]   en_rdata,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              err_wr,
    input  logic [3:0]        err_wdata,
    output logic [3:0]        err_flags
);
    logic              rx_bit;
    logic              rx_enabled;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              par_bad, stop_bad, overrun_hit, brk_hit;
    rx_err_t           set_v;

    uart_rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .async_in(rxd_in), .sync_out(rx_bit)
    );

    uart_rx_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_deframer (
        .clk(clk), .rst(rst), .enable(rx_enabled), .sub_tick(sub_tick),
        .rx_bit(rx_bit), .parity_en(parity_en), .parity_odd(parity_odd),
        .hold_full(rx_valid), .frame_done(frame_done),
        .frame_data(frame_data), .par_bad(par_bad), .stop_bad(stop_bad),
        .overrun_hit(overrun_hit)
    );

    uart_rx_break_det #(.DATA_W(DATA_W), .OVS(OVS)) u_break (
        .clk(clk), .rst(rst), .enable(rx_enabled), .sub_tick(sub_tick),
        .rx_bit(rx_bit), .parity_en(parity_en), .brk_hit(brk_hit)
    );

    always_comb begin
        set_v         = '0;
        set_v.overrun = overrun_hit;
        set_v.parity  = frame_done && par_bad;
        set_v.framing = frame_done && stop_bad;
        set_v.brk     = brk_hit;
    end

    uart_rx_regs #(.DATA_W(DATA_W), .EN_W(EN_W)) u_regs (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .err_wr(err_wr), .err_wdata(err_wdata), .err_set(set_v),
        .frame_done(frame_done), .frame_data(frame_data),
        .rd_strobe(rd_strobe), .en_code(en_rdata), .rx_enabled(rx_enabled),
        .err_q(err_flags), .hold_data(rx_data), .hold_valid(rx_valid)
    );
endmodule

// File: rtl/uart_rx_errcap_chk.sv
module uart_rx_errcap_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_enabled,
    input logic       frame_done,
    input logic       rd_strobe,
    input logic       rx_valid,
    input logic       err_wr,
    input logic [3:0] err_wdata,
    input logic [3:0] err_flags,
    input logic [3:0] set_bits
);
    // R10: without a clear write no flag ever drops
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !err_wr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R10: a clear with no competing error removes every masked flag
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (err_wr && set_bits == 4'b0000) |=> ((err_flags & $past(err_wdata)) == 4'b0000));

    // R10: a detected error always lands, even against a clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_bits != 4'b0000) |=> ((err_flags & $past(set_bits)) == $past(set_bits)));

    // R3: a finished byte always raises the valid flag
    p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> rx_valid);

    // R9: a read with no competing byte drops the valid flag
    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !frame_done) |=> !rx_valid);

    // R11: while disabled no byte can be captured
    p_off_no_byte_r11: assert property (@(posedge clk) disable iff (rst)
        !rx_enabled |=> !$rose(rx_valid));

    // R2: while the enable code is wrong no new flag appears
    p_off_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
        !rx_enabled |=> ((err_flags & ~$past(err_flags)) == 4'b0000));
endmodule

bind uart_rx_errcap uart_rx_errcap_chk u_chk (
    .clk(clk), .rst(rst), .rx_enabled(rx_enabled), .frame_done(frame_done),
    .rd_strobe(rd_strobe), .rx_valid(rx_valid), .err_wr(err_wr),
    .err_wdata(err_wdata), .err_flags(err_flags), .set_bits(set_v)
);

// File: tb/uart_rx_errcap_test.sv
`timescale 1ns/1ps
module uart_rx_errcap_test;
    localparam int BIT_CLKS = 64;   // 16 sub_ticks, one every 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic       parity_en = 1'b0, parity_odd = 1'b0;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = 4'd0;
    logic [3:0] en_rdata;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       err_wr = 1'b0;
    logic [3:0] err_wdata = 4'd0;
    logic [3:0] err_flags;

    int  n_checks = 0, n_fails = 0;
    bit  finished = 1'b0;

    logic [7:0] m_data;
    logic       m_valid;
    logic [3:0] m_err;

    uart_rx_errcap uut (
        .clk(clk), .rst(rst), .sub_tick(sub_tick), .rxd_in(rxd_in),
        .parity_en(parity_en), .parity_odd(parity_odd), .en_wr(en_wr),
        .en_wdata(en_wdata), .en_rdata(en_rdata), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_valid(rx_valid), .err_wr(err_wr),
        .err_wdata(err_wdata), .err_flags(err_flags)
    );

    always #2 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            sub_tick = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic good_parity(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_en(input logic [3:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic write_err(input logic [3:0] mask);
        @(negedge clk); err_wr = 1'b1; err_wdata = mask;
        @(negedge clk); err_wr = 1'b0;
        m_err &= ~mask;
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        m_valid = 1'b0;
    endtask

    // Drives one frame; the model is updated only when upd is set.
    task automatic send(input logic [7:0] d, input logic p_on, input logic p_odd,
                        input logic bad_par, input logic bad_stop, input logic upd);
        @(negedge clk);
        parity_en = p_on; parity_odd = p_odd;
        if (upd) begin
            if (m_valid) m_err[0] = 1'b1;
        end
        rxd_in = 1'b0; wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rxd_in = d[i]; wait_clks(BIT_CLKS);
        end
        if (p_on) begin
            rxd_in = good_parity(d, p_odd) ^ bad_par; wait_clks(BIT_CLKS);
        end
        rxd_in = !bad_stop; wait_clks(BIT_CLKS);
        rxd_in = 1'b1; wait_clks(2 * BIT_CLKS);
        if (upd) begin
            m_data = d; m_valid = 1'b1;
            if (p_on && bad_par) m_err[1] = 1'b1;
            if (bad_stop) m_err[2] = 1'b1;
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " data"},  rx_data,   m_data);
        check({tag, " valid"}, rx_valid,  m_valid);
        check({tag, " flags"}, err_flags, m_err);
    endtask

    task automatic hold_low(input int clks, input logic p_on);
        @(negedge clk);
        parity_en = p_on;
        rxd_in = 1'b0; wait_clks(clks);
        rxd_in = 1'b1; wait_clks(3 * BIT_CLKS);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20240607);
        m_data = 8'h00; m_valid = 1'b0; m_err = 4'h0;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);

        // R1: reset values
        check("R1 flags", err_flags, 4'h0);
        check("R1 valid", rx_valid, 1'b0);
        check("R1 data", rx_data, 8'h00);
        check("R1 enable", en_rdata, 4'h0);

        // R11: disabled receiver ignores a full frame
        send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_state("R11 off");

        // R2: a code other than 8 keeps the receiver off
        write_en(4'd1);
        check("R2 readback", en_rdata, 4'd1);
        send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_state("R2 wrong code");

        // R3: plain byte, LSB first
        write_en(4'd8);
        check("R2 on readback", en_rdata, 4'd8);
        send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_state("R3 byte");

        // R9: read strobe drops valid, data stays
        do_read();
        wait_clks(1);
        check_state("R9 read");

        // R4: even parity correct, then odd parity wrong
        send(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check_state("R4 even ok");
        do_read();
        send(8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check_state("R4 odd bad");
        do_read();
        write_err(4'b0010);
        check_state("R10 clear parity");

        // R6: overrun, second byte replaces the first
        send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_state("R6 overrun");
        // R5: framing on top of a second overrun
        send(8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check_state("R5 framing");
        // R10: selective clear keeps framing
        write_err(4'b0001);
        check_state("R10 selective");
        write_err(4'b0100);
        do_read();
        check_state("R10 clear framing");

        // R8: short glitch on the line
        hold_low(12, 1'b0);
        check_state("R8 glitch");

        // R7: low 10.75 bits without parity exceeds 160 sub_ticks
        hold_low(688, 1'b0);
        m_data = 8'h00; m_valid = 1'b1; m_err = m_err | 4'b1100;
        check_state("R7 break");
        do_read();
        write_err(4'b1111);

        // R7: same low time with parity stays under 176 sub_ticks
        hold_low(688, 1'b1);
        m_data = 8'h00; m_valid = 1'b1; m_err = m_err | 4'b0100;
        check_state("R7 no break with parity");

        // R11: disabling preserves flags and held byte
        write_en(4'd0);
        send(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_state("R11 preserved");
        write_en(4'd8);
        do_read();
        write_err(4'b1111);
        check_state("R11 re-enabled");

        // Random frames
        for (int k = 0; k < 60; k++) begin
            logic [7:0] d;
            logic p_on, p_odd, b_par, b_stop;
            d      = 8'($urandom);
            p_on   = 1'($urandom);
            p_odd  = 1'($urandom);
            b_par  = ($urandom % 8) == 0;
            b_stop = ($urandom % 8) == 0;
            if (b_stop) d[7] = 1'b1;
            if (($urandom % 2) == 0) do_read();
            send(d, p_on, p_odd, b_par, b_stop, 1'b1);
            check_state("R3 R4 R5 R6 random");
            if (($urandom % 3) == 0) begin
                write_err(4'($urandom));
                check("R10 random clear", err_flags, m_err);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule